// File: doc/BRIEF.md
# Single-Price Coin Vending Controller

This block is the sequencing core of a ten-selection drink dispenser that takes one kind of coin and charges three coins for any drink. It counts the coins inserted, lets a drink out only when the full price is held and the chosen slot still has stock, gives back the coins on request, and returns any coin offered once the price is already paid.

All decisions come from a constant lookup table. The table address is the current coin count joined with the coin, refund and "a stocked drink is selected" inputs. The table data is the next coin count plus the refund and dispense strobes. A priority encoder in front of the table reduces the ten select lines and ten stock sensors to one valid flag and one index. That keeps the table at 32 entries, where addressing it by all the raw inputs would need millions.

The inputs are expected to be synchronous pulses one clock wide. Every output comes straight from a flop.

Top module: `vend_unit`

## Requirements
- R1: While reset is low and after it is released, the coin count is 0 and both `releaseStrobe` and `refundStrobe` are all zero.
- R2: Each `coinPulse` without `refundBtn` raises the count by one, in the order 0, 1, 2, 3. Next-state and strobe values come from a table addressed by {count, coin, refund, valid selection}.
- R3: A selection made while fewer than three coins are held releases nothing and leaves the count unchanged.
- R4: At three coins, a valid selection of drink i sets only bit i of `releaseStrobe`, and only for one cycle. The count then returns to 0.
- R5: A selection whose `soldOut` bit is 1 is not dispensed, and the count stays at 3.
- R6: When several select bits are high, the lowest-numbered one whose `soldOut` bit is 0 is dispensed.
- R7: `refundBtn` with at least one coin held pulses `refundStrobe` for one cycle and clears the count to 0. `refundBtn` with no coins held has no effect.
- R8: A coin offered at three coins pulses `refundStrobe` for one cycle, and the count stays at 3.
- R9: `refundBtn` (with coins held) takes priority over a valid selection and over a coin in the same cycle. No drink is released, and the count goes to 0.
- R10: The outputs are registered. A strobe appears in the cycle after the clock edge that captures its cause, and never in the same cycle as that cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coinPulse | input | 1 | One-cycle pulse per accepted coin |
| refundBtn | input | 1 | One-cycle refund request |
| selBtn | input | 10 | Drink select buttons, bit i = drink i |
| soldOut | input | 10 | Stock sensors, bit i high = drink i empty |
| releaseStrobe | output | 10 | One-cycle release pulse for the dispensed drink |
| refundStrobe | output | 1 | One-cycle coin return pulse |

## Verification
The main function is tried with several input sequences:
- A plain three-coin purchase, followed by a repeat selection, shows that the count resets after a sale.
- Early selections interleaved with coins separate "ignored" from "counted".
- Sold-out and multi-button patterns show that the stock gating and the lowest-index priority are both applied.
- Refunds at zero and non-zero counts, an extra coin at full price, and refund combined with a selection each leave a different follow-up outcome, which exposes the hidden count through the release and refund strobes.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int PriceCoins = 3;
  localparam int CountW     = $clog2(PriceCoins + 1);
  localparam int AddrW      = CountW + 3;
  localparam int TableDepth = 2 ** AddrW;

  typedef logic [CountW-1:0] count_t;

  typedef struct packed {
    count_t nextCount;
    logic   refund;
    logic   dispense;
  } strobe_t;

  // Table contents: address = {count, coin, refund, validSel}
  function automatic strobe_t lookupEntry(logic [AddrW-1:0] addr);
    strobe_t e;
    count_t  cnt;
    logic    coin, refund, valid;
    cnt    = addr[AddrW-1:3];
    coin   = addr[2];
    refund = addr[1];
    valid  = addr[0];
    e = '0;
    if (refund && cnt != '0) begin
      e.nextCount = '0;
      e.refund    = 1'b1;
    end else if (cnt == count_t'(PriceCoins)) begin
      e.dispense  = valid;
      e.refund    = coin;
      e.nextCount = valid ? '0 : cnt;
    end else begin
      e.nextCount = coin ? count_t'(cnt + 1'b1) : cnt;
    end
    return e;
  endfunction
endpackage

// File: rtl/vend_table.sv
module vend_table
  import vend_pkg::*;
(
  input  logic [AddrW-1:0] addr,
  output strobe_t          entry
);
  strobe_t romData [TableDepth];

  for (genvar g = 0; g < TableDepth; g++) begin : g_rom
    assign romData[g] = lookupEntry(AddrW'(g));
  end

  assign entry = romData[addr];
endmodule

// File: rtl/vend_control.sv
module vend_control
  import vend_pkg::*;
#(
  parameter int NumSel = 10,
  localparam int IdxW  = $clog2(NumSel)
) (
  input  logic              clk,
  input  logic              rstN,
  input  count_t            coinCount,
  input  logic              coinPulse,
  input  logic              refundBtn,
  input  logic [NumSel-1:0] selBtn,
  input  logic [NumSel-1:0] soldOut,
  output strobe_t           ctrl,
  output logic [IdxW-1:0]   selIdx
);
  logic validSel;

  // lowest-numbered stocked selection wins
  always_comb begin
    validSel = 1'b0;
    selIdx   = '0;
    for (int i = NumSel - 1; i >= 0; i--) begin
      if (selBtn[i] && !soldOut[i]) begin
        validSel = 1'b1;
        selIdx   = IdxW'(i);
      end
    end
  end

  vend_table u_table (
    .addr  ({coinCount, coinPulse, refundBtn, validSel}),
    .entry (ctrl)
  );

  AST_COIN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    coinPulse && !refundBtn && coinCount != count_t'(PriceCoins)
    |=> coinCount == count_t'($past(coinCount) + 1'b1)); // R2

  AST_REFUND_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    refundBtn && coinCount != '0 |=> coinCount == '0); // R7

  AST_EXTRA_COIN_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    coinPulse && !refundBtn && !validSel && coinCount == count_t'(PriceCoins)
    |=> coinCount == count_t'(PriceCoins)); // R8

  AST_SOLDOUT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !refundBtn && !validSel && coinCount == count_t'(PriceCoins)
    |=> coinCount == count_t'(PriceCoins)); // R5
endmodule

// File: rtl/vend_datapath.sv
module vend_datapath
  import vend_pkg::*;
#(
  parameter int NumSel = 10,
  localparam int IdxW  = $clog2(NumSel)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           ctrl,
  input  logic [IdxW-1:0]   selIdx,
  output count_t            coinCount,
  output logic [NumSel-1:0] releaseStrobe,
  output logic              refundStrobe
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      coinCount     <= '0;
      releaseStrobe <= '0;
      refundStrobe  <= 1'b0;
    end else begin
      coinCount     <= ctrl.nextCount;
      refundStrobe  <= ctrl.refund;
      releaseStrobe <= ctrl.dispense ? (NumSel'(1) << selIdx) : '0;
    end
  end

  AST_RELEASE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(releaseStrobe)); // R4

  AST_RELEASE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    |releaseStrobe |=> releaseStrobe == '0); // R4

  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    |releaseStrobe |-> coinCount == '0); // R4

  AST_NO_FREE_DRINK: assert property (@(posedge clk) disable iff (!rstN)
    |releaseStrobe |-> $past(coinCount) == count_t'(PriceCoins)); // R3
endmodule

// File: rtl/vend_unit.sv
module vend_unit
  import vend_pkg::*;
#(
  parameter int NumSel = 10,
  localparam int IdxW  = $clog2(NumSel)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coinPulse,
  input  logic              refundBtn,
  input  logic [NumSel-1:0] selBtn,
  input  logic [NumSel-1:0] soldOut,
  output logic [NumSel-1:0] releaseStrobe,
  output logic              refundStrobe
);
  strobe_t         ctrl;
  logic [IdxW-1:0] selIdx;
  count_t          coinCount;

  vend_control #(.NumSel(NumSel)) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .coinCount (coinCount),
    .coinPulse (coinPulse),
    .refundBtn (refundBtn),
    .selBtn    (selBtn),
    .soldOut   (soldOut),
    .ctrl      (ctrl),
    .selIdx    (selIdx)
  );

  vend_datapath #(.NumSel(NumSel)) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .selIdx        (selIdx),
    .coinCount     (coinCount),
    .releaseStrobe (releaseStrobe),
    .refundStrobe  (refundStrobe)
  );

  AST_REFUND_BEATS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    refundStrobe && $past(refundBtn) |-> releaseStrobe == '0); // R9
endmodule

// File: tb/vend_unit_bench.sv
module vend_unit_bench;
  localparam int NumSel = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              coinPulse = 1'b0;
  logic              refundBtn = 1'b0;
  logic [NumSel-1:0] selBtn = '0;
  logic [NumSel-1:0] soldOut = '0;
  logic [NumSel-1:0] releaseStrobe;
  logic              refundStrobe;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic [NumSel-1:0] gotRel;
  logic              gotRef;

  always #10 clk = ~clk;

  vend_unit #(.NumSel(NumSel)) u_vend_unit (
    .clk(clk), .rstN(rstN), .coinPulse(coinPulse), .refundBtn(refundBtn),
    .selBtn(selBtn), .soldOut(soldOut),
    .releaseStrobe(releaseStrobe), .refundStrobe(refundStrobe)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // drive one input cycle, capture the strobes it produces
  task automatic step(logic coin, logic refund, logic [NumSel-1:0] sel,
                      logic [NumSel-1:0] sold);
    @(negedge clk);
    coinPulse = coin; refundBtn = refund; selBtn = sel; soldOut = sold;
    @(negedge clk);
    gotRel = releaseStrobe;
    gotRef = refundStrobe;
    coinPulse = 1'b0; refundBtn = 1'b0; selBtn = '0; soldOut = '0;
  endtask

  task automatic addCoins(int n);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0, '0, '0);
      check("R2 coin gives no strobe", {gotRel, gotRef}, '0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 release in reset", releaseStrobe, '0);
    check("R1 refund in reset", refundStrobe, 0);
    rstN = 1'b1;
    step(1'b0, 1'b0, 10'h3ff, '0);
    check("R1 nothing after reset", {gotRel, gotRef}, '0);
  endtask

  task automatic t_purchase;
    addCoins(3);
    step(1'b0, 1'b0, 10'h020, '0);
    check("R4 drink 5 released", gotRel, 10'h020);
    step(1'b0, 1'b0, '0, '0);
    check("R4 release is one cycle", gotRel, '0);
    step(1'b0, 1'b0, 10'h020, '0);
    check("R4 count back to 0", gotRel, '0);
  endtask

  task automatic t_early_select;
    addCoins(2);
    step(1'b0, 1'b0, 10'h001, '0);
    check("R3 select at 2 coins ignored", {gotRel, gotRef}, '0);
    addCoins(1);
    step(1'b0, 1'b0, 10'h002, '0);
    check("R3 count kept at 2 then 3", gotRel, 10'h002);
  endtask

  task automatic t_soldout;
    addCoins(3);
    step(1'b0, 1'b0, 10'h004, 10'h004);
    check("R5 sold-out not dispensed", {gotRel, gotRef}, '0);
    step(1'b0, 1'b0, 10'h008, 10'h004);
    check("R5 still at 3 coins", gotRel, 10'h008);
  endtask

  task automatic t_priority;
    addCoins(3);
    step(1'b0, 1'b0, 10'h092, 10'h002);
    check("R6 lowest stocked wins", gotRel, 10'h010);
  endtask

  task automatic t_refund;
    step(1'b0, 1'b1, '0, '0);
    check("R7 refund at 0 coins ignored", {gotRel, gotRef}, '0);
    addCoins(2);
    step(1'b0, 1'b1, '0, '0);
    check("R7 refund strobe", gotRef, 1);
    step(1'b0, 1'b0, '0, '0);
    check("R7 refund one cycle", gotRef, 0);
    addCoins(2);
    step(1'b0, 1'b0, 10'h040, '0);
    check("R7 count cleared by refund", gotRel, '0);
    addCoins(1);
    step(1'b0, 1'b0, 10'h040, '0);
    check("R7 purchase after refund", gotRel, 10'h040);
  endtask

  task automatic t_extra_coin;
    addCoins(3);
    step(1'b1, 1'b0, '0, '0);
    check("R8 extra coin returned", gotRef, 1);
    check("R8 no release on extra coin", gotRel, '0);
    step(1'b0, 1'b0, 10'h200, '0);
    check("R8 still at 3 coins", gotRel, 10'h200);
  endtask

  task automatic t_refund_priority;
    addCoins(3);
    step(1'b1, 1'b1, 10'h001, '0);
    check("R9 refund wins strobe", gotRef, 1);
    check("R9 no release with refund", gotRel, '0);
    step(1'b0, 1'b0, 10'h001, '0);
    check("R9 count cleared", gotRel, '0);
  endtask

  task automatic t_latency;
    addCoins(3);
    @(negedge clk);
    selBtn = 10'h100;
    #1;
    check("R10 no same-cycle release", releaseStrobe, '0);
    @(negedge clk);
    selBtn = '0;
    check("R10 release next cycle", releaseStrobe, 10'h100);
  endtask

  initial begin
    t_reset();
    t_purchase();
    t_early_select();
    t_soldout();
    t_priority();
    t_refund();
    t_extra_coin();
    t_refund_priority();
    t_latency();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule